// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block passes doorbell notifications between an application processor and a system control processor. Each direction has a secure channel of three registers: a status word, a write-one-to-set word and a write-one-to-clear word. A sender raises a doorbell by setting a slot bit. The receiver gets an interrupt and acknowledges by clearing that bit. The sender polls the same status bit to learn when the slot is free again.

Each processor reaches the block through its own simple register port. A port carries an address, write data, a write enable and a secure-access flag, and it returns read data combinationally from the registered state. The top status bit of each channel is not a doorbell slot. It is a sticky flag that records an attempted non-secure access to that channel. That leaves 31 doorbell slots per direction.

Top module: `doorbell_mbox`

## Requirements
- R1: The application-to-controller channel (A) has its status, set and clear words at byte offsets 0x300, 0x308 and 0x310. The controller-to-application channel (B) has them at 0x200, 0x208 and 0x210. Both ports reach all six words with identical behaviour, and status bit k stands for slot k.
- R2: A secure write to a set word sets every status bit 30:0 whose write-data bit is 1 and leaves bits written as 0 unchanged. The new value is readable in the cycle after the write.
- R3: A secure write to a clear word clears every status bit (31:0) whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R4: After a synchronous active-low reset, both status words read zero and both interrupt outputs are low.
- R5: A non-secure write to any of a channel's three words changes no doorbell bit 30:0 and sets bit 31 of that channel's status.
- R6: A non-secure read of any offset returns zero.
- R7: Bit 31 written as 1 through a set word is ignored.
- R8: Each channel's interrupt is high exactly when any of its status bits 30:0 is set. It comes from a register and changes in the same cycle as the status. Bit 31 alone does not raise it.
- R9: The set and clear words read as zero. Reading a status word returns its value and leaves it unchanged.
- R10: When the two ports set and clear the same bit in the same cycle, the bit ends up set.
- R11: An unmapped offset reads as zero, and a write to it changes neither status word.
- R12: A secure write to a status word changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ap_addr | input | 12 | Application port byte offset |
| ap_wdata | input | 32 | Application port write data |
| ap_we | input | 1 | Application port write enable |
| ap_secure | input | 1 | Application port access is secure |
| ap_rdata | output | 32 | Application port read data |
| ctl_addr | input | 12 | Controller port byte offset |
| ctl_wdata | input | 32 | Controller port write data |
| ctl_we | input | 1 | Controller port write enable |
| ctl_secure | input | 1 | Controller port access is secure |
| ctl_rdata | output | 32 | Controller port read data |
| irq_to_ctl | output | 1 | Doorbell pending on channel A |
| irq_to_ap | output | 1 | Doorbell pending on channel B |

## Verification
The per-bit assertions on channel A look only at application-port writes. They assume the controller port issues no write in the same cycle, and they include that assumption in the antecedent, so writes from both ports in one cycle only ever exercise the set-wins rule. The stimulus always holds both write enables low between operations. Inputs change one time unit after the rising edge, and reads are sampled at the falling edge. A single collision test drives both ports in the same cycle, and the interrupt-follows-status property covers that case.

// File: rtl/mbox_pkg.sv
// Shared constants for the doorbell mailbox: widths and the address map.
// Assumes byte offsets fit in 12 bits and the channel count is fixed at two.
package mbox_pkg;
    localparam int MB_ADDR_W = 12;
    localparam int MB_DATA_W = 32;
    localparam int MB_NCH    = 2;
    localparam int MB_NPORT  = 2;
    localparam int CH_A      = 0;   // application -> controller
    localparam int CH_B      = 1;   // controller -> application
    localparam int OFS_STAT  = 'h00;
    localparam int OFS_SET   = 'h08;
    localparam int OFS_CLR   = 'h10;

    // Base offset of a channel's register group
    function automatic int chan_base(input int ch);
        return (ch == CH_A) ? 'h300 : 'h200;
    endfunction

    // True when the offset names any channel register
    function automatic logic is_mapped(input logic [MB_ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int c = 0; c < MB_NCH; c++) begin
            if (int'(a) == chan_base(c) + OFS_STAT ||
                int'(a) == chan_base(c) + OFS_SET  ||
                int'(a) == chan_base(c) + OFS_CLR)
                hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/mbox_decode.sv
// Per-port decoder. It turns one access into set and clear masks for every
// channel and selects the status word to read. A non-secure write to any word
// of a channel becomes a request to set that channel's top (violation) bit.
// Assumes a single access per port per cycle.
module mbox_decode #(
    parameter int ADDR_W = mbox_pkg::MB_ADDR_W,
    parameter int DATA_W = mbox_pkg::MB_DATA_W,
    parameter int NCH    = mbox_pkg::MB_NCH
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        we,
    input  logic                        secure,
    output logic [NCH-1:0][DATA_W-1:0]  set_mask,
    output logic [NCH-1:0][DATA_W-1:0]  clr_mask,
    output logic [NCH-1:0]              rd_sel
);
    import mbox_pkg::*;

    localparam int SLOT_W = DATA_W - 1;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit_stat, hit_set, hit_clr, hit_any;
        // Match the offset against this channel's three words
        assign hit_stat = (addr == ADDR_W'(chan_base(c) + OFS_STAT));
        assign hit_set  = (addr == ADDR_W'(chan_base(c) + OFS_SET));
        assign hit_clr  = (addr == ADDR_W'(chan_base(c) + OFS_CLR));
        assign hit_any  = hit_stat | hit_set | hit_clr;
        // Slot bits come only from secure set writes; the top bit only from violations
        assign set_mask[c] = {we & ~secure & hit_any,
                              (we & secure & hit_set) ? wdata[SLOT_W-1:0] : {SLOT_W{1'b0}}};
        // Secure clear writes may clear every bit, the violation flag included
        assign clr_mask[c] = (we & secure & hit_clr) ? wdata : {DATA_W{1'b0}};
        // Only a secure access to the status word returns data
        assign rd_sel[c]   = secure & hit_stat;
    end
endmodule

// File: rtl/mbox_channel.sv
// One doorbell channel: status register and registered interrupt. Requests
// from all ports are merged; set has priority over clear on the same bit.
// Assumes masks are already qualified by the decoders.
module mbox_channel #(
    parameter int DATA_W = mbox_pkg::MB_DATA_W,
    parameter int NPORT  = mbox_pkg::MB_NPORT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0][DATA_W-1:0]  set_req,
    input  logic [NPORT-1:0][DATA_W-1:0]  clr_req,
    output logic [DATA_W-1:0]             status,
    output logic                          irq
);
    logic [DATA_W-1:0] set_all, clr_all, status_nxt;

    // Merge port requests and form the next status, set winning
    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int p = 0; p < NPORT; p++) begin
            set_all = set_all | set_req[p];
            clr_all = clr_all | clr_req[p];
        end
        status_nxt = (status & ~clr_all) | set_all;
    end

    // Hold status and an interrupt that tracks the doorbell slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_nxt;
            irq    <= |status_nxt[DATA_W-2:0];
        end
    end
endmodule

// File: rtl/mbox_rdmux.sv
// Read-data selector for one port: AND-OR of the channel status words.
// Assumes at most one select bit is high.
module mbox_rdmux #(
    parameter int DATA_W = mbox_pkg::MB_DATA_W,
    parameter int NCH    = mbox_pkg::MB_NCH
) (
    input  logic [NCH-1:0]              sel,
    input  logic [NCH-1:0][DATA_W-1:0]  stat,
    output logic [DATA_W-1:0]           rdata
);
    // Combine the selected status words; no selection gives zero
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++)
            if (sel[c]) rdata = rdata | stat[c];
    end
endmodule

// File: rtl/doorbell_mbox.sv
// Secure doorbell mailbox top. Two register ports (application, controller)
// share two channels. Port p decodes into per-channel masks, each channel keeps
// its status and interrupt, and each port reads back through its own mux.
// Assumes both ports are synchronous to clk.
module doorbell_mbox #(
    parameter int ADDR_W = mbox_pkg::MB_ADDR_W,
    parameter int DATA_W = mbox_pkg::MB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic [DATA_W-1:0] ap_wdata,
    input  logic              ap_we,
    input  logic              ap_secure,
    output logic [DATA_W-1:0] ap_rdata,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_we,
    input  logic              ctl_secure,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              irq_to_ctl,
    output logic              irq_to_ap
);
    import mbox_pkg::*;

    localparam int NCH   = MB_NCH;
    localparam int NPORT = MB_NPORT;

    logic [NPORT-1:0][ADDR_W-1:0]           p_addr;
    logic [NPORT-1:0][DATA_W-1:0]           p_wdata, p_rdata;
    logic [NPORT-1:0]                       p_we, p_secure;
    logic [NPORT-1:0][NCH-1:0][DATA_W-1:0]  set_pc, clr_pc;
    logic [NCH-1:0][NPORT-1:0][DATA_W-1:0]  set_cp, clr_cp;
    logic [NPORT-1:0][NCH-1:0]              rd_sel;
    logic [NCH-1:0][DATA_W-1:0]             stat_q;
    logic [NCH-1:0]                         irq_q;

    // Gather the named ports into indexed form
    assign p_addr   = {ctl_addr,   ap_addr};
    assign p_wdata  = {ctl_wdata,  ap_wdata};
    assign p_we     = {ctl_we,     ap_we};
    assign p_secure = {ctl_secure, ap_secure};
    assign ap_rdata  = p_rdata[0];
    assign ctl_rdata = p_rdata[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbox_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_dec (
            .addr     (p_addr[p]),
            .wdata    (p_wdata[p]),
            .we       (p_we[p]),
            .secure   (p_secure[p]),
            .set_mask (set_pc[p]),
            .clr_mask (clr_pc[p]),
            .rd_sel   (rd_sel[p])
        );
        mbox_rdmux #(.DATA_W(DATA_W), .NCH(NCH)) u_rd (
            .sel   (rd_sel[p]),
            .stat  (stat_q),
            .rdata (p_rdata[p])
        );
        for (genvar c = 0; c < NCH; c++) begin : g_xp
            // Transpose port-major masks to channel-major
            assign set_cp[c][p] = set_pc[p][c];
            assign clr_cp[c][p] = clr_pc[p][c];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        mbox_channel #(.DATA_W(DATA_W), .NPORT(NPORT)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_cp[c]),
            .clr_req (clr_cp[c]),
            .status  (stat_q[c]),
            .irq     (irq_q[c])
        );
    end

    assign irq_to_ctl = irq_q[CH_A];
    assign irq_to_ap  = irq_q[CH_B];
endmodule

// File: rtl/mbox_checker.sv
// Property checker for doorbell_mbox, bound to every instance. Channel A is
// checked through application-port writes issued while the controller port
// is idle; the interrupt and read-zero rules are checked on both channels.
module mbox_checker #(
    parameter int ADDR_W = mbox_pkg::MB_ADDR_W,
    parameter int DATA_W = mbox_pkg::MB_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ap_addr,
    input logic [DATA_W-1:0] ap_wdata,
    input logic              ap_we,
    input logic              ap_secure,
    input logic [DATA_W-1:0] ap_rdata,
    input logic              ctl_we,
    input logic              ctl_secure,
    input logic [DATA_W-1:0] ctl_rdata,
    input logic              irq_a,
    input logic              irq_b,
    input logic [DATA_W-1:0] stat_a,
    input logic [DATA_W-1:0] stat_b
);
    import mbox_pkg::*;

    localparam int TOP = DATA_W - 1;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(chan_base(CH_A) + OFS_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(chan_base(CH_A) + OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(chan_base(CH_A) + OFS_CLR);

    logic ap_a_sset, ap_a_sclr, ap_a_ns, ap_unmapped;
    assign ap_a_sset   = ap_we && ap_secure && ap_addr == A_SET && !ctl_we;
    assign ap_a_sclr   = ap_we && ap_secure && ap_addr == A_CLR && !ctl_we;
    assign ap_a_ns     = ap_we && !ap_secure && !ctl_we &&
                         (ap_addr == A_STAT || ap_addr == A_SET || ap_addr == A_CLR);
    assign ap_unmapped = ap_we && !ctl_we && !is_mapped(ap_addr);

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ap_a_sset |=> ((stat_a[TOP-1:0] & $past(ap_wdata[TOP-1:0])) == $past(ap_wdata[TOP-1:0]))); // R2
    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ap_a_sset |=> ((stat_a & ~$past(ap_wdata)) == ($past(stat_a) & ~$past(ap_wdata)))); // R2
    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ap_a_sclr |=> ((stat_a & $past(ap_wdata)) == '0)); // R3
    AST_NS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ap_a_ns |=> (stat_a[TOP] && stat_a[TOP-1:0] == $past(stat_a[TOP-1:0]))); // R5
    AST_NS_RD_AP: assert property (@(posedge clk) disable iff (!rst_n)
        !ap_secure |-> ap_rdata == '0); // R6
    AST_NS_RD_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_secure |-> ctl_rdata == '0); // R6
    AST_SET_TOP_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        ap_a_sset |=> stat_a[TOP] == $past(stat_a[TOP])); // R7
    AST_IRQ_A: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a == (|stat_a[TOP-1:0])); // R8
    AST_IRQ_B: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b == (|stat_b[TOP-1:0])); // R8
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ap_unmapped |=> ($stable(stat_a) && $stable(stat_b))); // R11
endmodule

bind doorbell_mbox mbox_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mbox_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ap_addr    (ap_addr),
    .ap_wdata   (ap_wdata),
    .ap_we      (ap_we),
    .ap_secure  (ap_secure),
    .ap_rdata   (ap_rdata),
    .ctl_we     (ctl_we),
    .ctl_secure (ctl_secure),
    .ctl_rdata  (ctl_rdata),
    .irq_a      (irq_to_ctl),
    .irq_b      (irq_to_ap),
    .stat_a     (stat_q[0]),
    .stat_b     (stat_q[1])
);

// File: tb/tb_doorbell_mbox.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks apply accesses, update a requirement-level
// model and queue expected read results; a falling-edge monitor compares.
module tb_doorbell_mbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ap_addr = '0, ctl_addr = '0;
    logic [31:0] ap_wdata = '0, ctl_wdata = '0;
    logic        ap_we = 1'b0, ctl_we = 1'b0;
    logic        ap_secure = 1'b1, ctl_secure = 1'b1;
    logic [31:0] ap_rdata, ctl_rdata;
    logic        irq_to_ctl, irq_to_ap;

    always #2.5 clk = ~clk;

    doorbell_mbox dut (
        .clk(clk), .rst_n(rst_n),
        .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_we(ap_we),
        .ap_secure(ap_secure), .ap_rdata(ap_rdata),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we),
        .ctl_secure(ctl_secure), .ctl_rdata(ctl_rdata),
        .irq_to_ctl(irq_to_ctl), .irq_to_ap(irq_to_ap)
    );

    typedef struct {
        int          port;
        logic [31:0] rd;
        logic        ia;
        logic        ib;
        string       tag;
    } item_t;

    item_t       sbq[$];
    logic        rd_strobe = 1'b0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] m_stat[2] = '{32'h0, 32'h0};
    bit          done = 0;

    // Channel bases: A = 0x300, B = 0x200; words at +0, +8, +0x10
    function automatic int base(input int c);
        return (c == 0) ? 'h300 : 'h200;
    endfunction

    // Model: accumulate one port's write into set/clear masks
    function automatic void acc(input int a, input logic [31:0] d, input logic s,
                                inout logic [31:0] sm[2], inout logic [31:0] cm[2]);
        for (int c = 0; c < 2; c++) begin
            if (a == base(c) || a == base(c) + 8 || a == base(c) + 'h10) begin
                if (!s)                     sm[c][31] = 1'b1;
                else if (a == base(c) + 8)  sm[c] = sm[c] | (d & 32'h7FFF_FFFF);
                else if (a == base(c) + 16) cm[c] = cm[c] | d;
            end
        end
    endfunction

    // Drive writes on either or both ports for one cycle and update the model
    task automatic wr2(input logic w0, input int a0, input logic [31:0] d0, input logic s0,
                       input logic w1, input int a1, input logic [31:0] d1, input logic s1);
        logic [31:0] sm[2] = '{32'h0, 32'h0};
        logic [31:0] cm[2] = '{32'h0, 32'h0};
        ap_we = w0;  ap_addr = 12'(a0);  ap_wdata = d0;  ap_secure = s0;
        ctl_we = w1; ctl_addr = 12'(a1); ctl_wdata = d1; ctl_secure = s1;
        if (w0) acc(a0, d0, s0, sm, cm);
        if (w1) acc(a1, d1, s1, sm, cm);
        @(posedge clk); #1;
        for (int c = 0; c < 2; c++) m_stat[c] = (m_stat[c] & ~cm[c]) | sm[c];
        ap_we = 1'b0; ctl_we = 1'b0; ap_secure = 1'b1; ctl_secure = 1'b1;
    endtask

    task automatic wr(input int p, input int a, input logic [31:0] d, input logic s);
        if (p == 0) wr2(1'b1, a, d, s, 1'b0, 0, 32'h0, 1'b1);
        else        wr2(1'b0, 0, 32'h0, 1'b1, 1'b1, a, d, s);
    endtask

    // Present a read for one cycle and queue the expected result
    task automatic rd(input int p, input int a, input logic s, input logic [31:0] exp, input string tag);
        item_t it;
        if (p == 0) begin ap_addr = 12'(a); ap_secure = s; end
        else begin ctl_addr = 12'(a); ctl_secure = s; end
        it.port = p; it.rd = exp; it.tag = tag;
        it.ia = |m_stat[0][30:0]; it.ib = |m_stat[1][30:0];
        sbq.push_back(it);
        rd_strobe = 1'b1;
        @(posedge clk); #1;
        rd_strobe = 1'b0; ap_secure = 1'b1; ctl_secure = 1'b1;
    endtask

    // Read a status word and expect the model value
    task automatic rs(input int p, input int c, input string tag);
        rd(p, base(c), 1'b1, m_stat[c], tag);
    endtask

    // Monitor: compare read data and both interrupts away from the edge
    always @(negedge clk) begin
        if (rd_strobe && sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            act = (it.port == 0) ? ap_rdata : ctl_rdata;
            checks++;
            if (act !== it.rd || irq_to_ctl !== it.ia || irq_to_ap !== it.ib) begin
                errors++;
                $display("FAIL %s: rdata=%h irqA=%b irqB=%b expected rdata=%h irqA=%b irqB=%b",
                         it.tag, act, irq_to_ctl, irq_to_ap, it.rd, it.ia, it.ib);
            end
        end
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R4: reset state
        rs(0, 0, "R4 status A after reset");
        rs(1, 1, "R4 status B after reset");
        // R9: set and clear words read zero
        rd(0, 'h308, 1'b1, 32'h0, "R9 set word reads zero");
        rd(1, 'h210, 1'b1, 32'h0, "R9 clear word reads zero");
        // R2, R8: secure set raises slots and the interrupt next cycle
        wr(0, 'h308, 32'h0000_0005, 1'b1);
        rs(0, 0, "R2 R8 set slots 0 and 2");
        rs(1, 0, "R1 controller port sees channel A");
        wr(0, 'h308, 32'h0000_0002, 1'b1);
        rs(0, 0, "R2 zero bits keep value");
        // R9: repeated status read without side effects
        rs(0, 0, "R9 status reread unchanged");
        // R3: clear one slot, then a zero clear
        wr(1, 'h310, 32'h0000_0001, 1'b1);
        rs(1, 0, "R3 clear slot 0");
        wr(1, 'h310, 32'h0, 1'b1);
        rs(1, 0, "R3 zero clear keeps value");
        wr(1, 'h310, 32'h7FFF_FFFF, 1'b1);
        rs(0, 0, "R8 all slots cleared drops irq");
        // R1, R8: channel B slot 30
        wr(1, 'h208, 32'h4000_0000, 1'b1);
        rs(0, 1, "R1 R8 channel B slot 30");
        wr(0, 'h210, 32'h4000_0000, 1'b1);
        rs(0, 1, "R1 channel B acknowledged");
        // R7: top bit through the set word is ignored
        wr(0, 'h308, 32'h8000_0000, 1'b1);
        rs(0, 0, "R7 set of bit 31 ignored");
        // R5, R6, R8: non-secure write flags violation only
        wr(0, 'h308, 32'h0000_0003, 1'b0);
        rs(0, 0, "R5 R8 nonsecure set flags bit 31");
        rd(0, 'h300, 1'b0, 32'h0, "R6 nonsecure read is zero");
        rd(1, 'h200, 1'b0, 32'h0, "R6 nonsecure read B is zero");
        // R3: clear the violation flag
        wr(0, 'h310, 32'h8000_0000, 1'b1);
        rs(0, 0, "R3 clear bit 31");
        // R5: non-secure write to B status word
        wr(1, 'h200, 32'h0000_00FF, 1'b0);
        rs(1, 1, "R5 nonsecure status write B");
        wr(1, 'h210, 32'h8000_0000, 1'b1);
        rs(1, 1, "R3 clear bit 31 on B");
        // R12: secure write to status word ignored
        wr(0, 'h308, 32'h0000_0010, 1'b1);
        wr(0, 'h300, 32'h0000_1234, 1'b1);
        rs(0, 0, "R12 status write ignored");
        // R11: unmapped accesses
        wr(0, 'h304, 32'hFFFF_FFFF, 1'b1);
        rd(0, 'h304, 1'b1, 32'h0, "R11 unmapped reads zero");
        wr(1, 'h100, 32'hFFFF_FFFF, 1'b1);
        rs(0, 0, "R11 unmapped write ignored A");
        rs(0, 1, "R11 unmapped write ignored B");
        // R10: same-cycle set and clear of slot 4 -> set wins; slot 5 only cleared
        wr(0, 'h308, 32'h0000_0020, 1'b1);
        wr2(1'b1, 'h308, 32'h0000_0010, 1'b1, 1'b1, 'h310, 32'h0000_0030, 1'b1);
        rs(0, 0, "R10 set wins over clear");
        rd(0, 'h300, 1'b1, 32'h0000_0010, "R10 literal result");
        wr(1, 'h310, 32'hFFFF_FFFF, 1'b1);
        rs(0, 0, "R8 final clear");
        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule